// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block divides each nominal bit on a CAN bus into time quanta and tracks where the node is within the bit. A programmable prescaler turns the system clock into quantum ticks. The bit is a fixed sequence: one synchronisation quantum, then a propagation segment, then phase segment 1, then phase segment 2. The lengths of the last three are set by configuration inputs.

The unit gives the bit-stream logic two strobes. The sample strobe marks the end of phase segment 1, and the line value taken at that point is held on an output. The transmit strobe marks the start of each bit, which is when a transmitter drives its next bit.

A dominant-going edge on the received line keeps the node aligned with the bus. While the bus is idle, such an edge restarts the bit. During a frame, a late edge lengthens phase segment 1 and an early edge shortens phase segment 2. In both cases the correction is limited to the resync jump width. Edges are resolved to a whole quantum: each edge is acted on at the quantum tick that ends the quantum in which it arrived.

Top module: `can_bit_timing`

## Requirements
- R1: A quantum tick (`tq_o` high for one clock) occurs every `brp_i`+1 clocks.
- R2: While reset is asserted, `seg_o` is 0 (sync), `sample_o` and `tx_point_o` are low, and `rx_bit_o` is 1 (recessive).
- R3: The segments run in the order sync, propagation, phase 1, phase 2, and then wrap back to sync. Sync is 1 quantum. Propagation is `prop_len_i`+1 quanta and phase 1 is `ph1_len_i`+1 quanta. Phase 2 is `ph2_len_i`+1 quanta, except that a field value of 0 gives 2 quanta. An unadjusted bit therefore spans the sum of these four lengths.
- R4: `seg_o` encodes the segment as 0 = sync, 1 = propagation, 2 = phase 1 and 3 = phase 2. `sample_o` pulses with the tick that ends phase 1. `tx_point_o` pulses with the tick that begins sync. The two strobes never coincide.
- R5: At each sample strobe, `rx_bit_o` takes the synchronised value of `rx_i` and holds it until the next sample strobe.
- R6: A resync edge can arrive in the quantum whose index after the sync quantum is e, where e ≥ 1 and the quantum lies in propagation or phase 1. Such an edge lengthens phase 1 by min(e, `sjw_i`+1).
- R7: A resync edge can arrive in a phase 2 quantum that precedes the nominal next sync quantum by e quanta. If e ≤ `sjw_i`+1, that quantum is taken as the sync of a new bit: propagation follows, and `tx_point_o` pulses as it ends. Otherwise phase 2 is shortened by `sjw_i`+1. In both cases the next sample moves earlier by min(e, `sjw_i`+1).
- R8: An edge that falls in the sync quantum changes nothing.
- R9: Only a 1-to-0 transition of `rx_i` counts as an edge. A rising transition has no effect on timing.
- R10: At most one resynchronisation is applied per bit. A later edge in the same bit is ignored.
- R11: No resynchronisation occurs while `tx_i` is 0 (the node is driving dominant).
- R12: With `idle_i` high, an edge hard-synchronises. The quantum holding the edge becomes the sync quantum, `tx_point_o` pulses at its end, and the next sample comes `prop`+`ph1` quanta later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brp_i | input | BRP_W | Prescaler: clocks per quantum minus one |
| prop_len_i | input | LEN_W | Propagation segment length minus one |
| ph1_len_i | input | LEN_W | Phase 1 length minus one |
| ph2_len_i | input | LEN_W | Phase 2 length minus one (0 gives 2) |
| sjw_i | input | SJW_W | Resync jump width minus one |
| idle_i | input | 1 | Bus idle: edges hard-synchronise |
| tx_i | input | 1 | Bit the node is transmitting (0 = dominant) |
| rx_i | input | 1 | Received bus line, asynchronous |
| tq_o | output | 1 | Quantum tick strobe |
| seg_o | output | 2 | Current segment code |
| sample_o | output | 1 | Sample point strobe |
| tx_point_o | output | 1 | Transmit point strobe |
| rx_bit_o | output | 1 | Line value captured at the last sample point |

## Verification
The assertions assume that the configuration inputs change only while reset is asserted. A mid-run decrease of `brp_i` could leave the prescaler count above its limit. A changed segment length could also break the bounds on the jump-width counters. The bench applies its second configuration under reset for this reason. Each `rx_i` transition is driven one clock after a quantum tick, and the prescaler gives five clocks per quantum. Each edge therefore clears the two-stage synchroniser well before the next tick and lands in a known quantum. The stimulus also keeps `tx_i` and `idle_i` steady within each measured bit.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
`timescale 1ns/1ps
module can_bt_prescaler #(
  parameter int BRP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q >= brp_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + BRP_W'(1);
  end

  assign tick_o = (cnt_q == brp_i);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= brp_i); // R1
  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && brp_i != '0) |=> !tick_o); // R1
endmodule

// File: rtl/can_bt_edge.sv
`timescale 1ns/1ps
module can_bt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  output logic rx_o,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q, pend_q, fall_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_now = s3_q & ~s2_q;

  // edge held until the quantum that contains it ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (tick_i)   pend_q <= 1'b0;
    else if (fall_now) pend_q <= 1'b1;
  end

  assign rx_o   = s2_q;
  assign edge_o = pend_q | fall_now;

  AST_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> !s3_q); // R9
endmodule

// File: rtl/can_bt_seq.sv
`timescale 1ns/1ps
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             idle_i,
  input  logic             tx_i,
  input  logic             rx_i,
  input  logic [LEN_W-1:0] prop_i,
  input  logic [LEN_W-1:0] ph1_i,
  input  logic [LEN_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic [1:0]       seg_o,
  output logic             sample_o,
  output logic             tx_point_o,
  output logic             rx_bit_o
);
  localparam int CW = ((LEN_W > SJW_W) ? LEN_W : SJW_W) + 3;

  logic [CW-1:0] prop_len, ph1_len, ph2_len, sjw_len;
  logic [CW-1:0] cur_len, e_late, e_early;
  logic [CW-1:0] q_q, q_d, ext_q, ext_d, shr_q, shr_d;
  seg_e          seg_q, seg_d;
  logic          done_q, done_d, rx_bit_q;
  logic          sample_d, txp_d, adopt, hard, resync_ok;

  always_comb begin
    prop_len = CW'(prop_i) + CW'(1);
    ph1_len  = CW'(ph1_i) + CW'(1);
    ph2_len  = (ph2_i == '0) ? CW'(2) : CW'(ph2_i) + CW'(1);
    sjw_len  = CW'(sjw_i) + CW'(1);
  end

  assign hard      = tick_i & edge_i & idle_i;
  assign resync_ok = tick_i & edge_i & ~idle_i & tx_i & ~done_q;

  always_comb begin
    seg_d    = seg_q;
    q_d      = q_q;
    ext_d    = ext_q;
    shr_d    = shr_q;
    done_d   = done_q;
    sample_d = 1'b0;
    txp_d    = 1'b0;
    adopt    = 1'b0;
    cur_len  = CW'(1);
    e_late   = (seg_q == SEG_PH1) ? prop_len + q_q + CW'(1) : q_q + CW'(1);
    e_early  = ph2_len - q_q;
    if (tick_i) begin
      if (hard) begin
        seg_d  = SEG_PROP;
        q_d    = '0;
        ext_d  = '0;
        shr_d  = '0;
        done_d = 1'b1;
        txp_d  = 1'b1;
      end else begin
        if (resync_ok && (seg_q == SEG_PROP || seg_q == SEG_PH1)) begin
          ext_d  = (e_late > sjw_len) ? sjw_len : e_late;
          done_d = 1'b1;
        end else if (resync_ok && seg_q == SEG_PH2) begin
          done_d = 1'b1;
          if (e_early <= sjw_len) adopt = 1'b1;
          else                    shr_d = sjw_len;
        end
        if (adopt) begin
          // edge quantum becomes the sync of a new bit
          seg_d = SEG_PROP;
          q_d   = '0;
          ext_d = '0;
          shr_d = '0;
          txp_d = 1'b1;
        end else begin
          unique case (seg_q)
            SEG_SYNC: cur_len = CW'(1);
            SEG_PROP: cur_len = prop_len;
            SEG_PH1:  cur_len = ph1_len + ext_d;
            default:  cur_len = ph2_len - shr_d;
          endcase
          if (q_q + CW'(1) >= cur_len) begin
            q_d = '0;
            unique case (seg_q)
              SEG_SYNC: seg_d = SEG_PROP;
              SEG_PROP: seg_d = SEG_PH1;
              SEG_PH1: begin
                seg_d    = SEG_PH2;
                sample_d = 1'b1;
              end
              default: begin
                seg_d  = SEG_SYNC;
                ext_d  = '0;
                shr_d  = '0;
                done_d = 1'b0;
                txp_d  = 1'b1;
              end
            endcase
          end else begin
            q_d = q_q + CW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= SEG_SYNC;
      q_q      <= '0;
      ext_q    <= '0;
      shr_q    <= '0;
      done_q   <= 1'b0;
      rx_bit_q <= 1'b1;
    end else begin
      seg_q  <= seg_d;
      q_q    <= q_d;
      ext_q  <= ext_d;
      shr_q  <= shr_d;
      done_q <= done_d;
      if (sample_d) rx_bit_q <= rx_i;
    end
  end

  assign seg_o      = seg_q;
  assign sample_o   = sample_d;
  assign tx_point_o = txp_d;
  assign rx_bit_o   = rx_bit_q;

  AST_SAMPLE_IN_PH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> seg_q == SEG_PH1); // R4
  AST_TXP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_point_o |=> (seg_q == SEG_SYNC || seg_q == SEG_PROP)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, tx_point_o})); // R4
  AST_EXT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= sjw_len); // R6
  AST_SHR_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_q <= sjw_len); // R7
  AST_NO_RESYNC_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !tx_i && !idle_i && (seg_q == SEG_PROP || seg_q == SEG_PH1))
    |=> ext_q == $past(ext_q)); // R11
  AST_ONE_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && done_q && !idle_i && seg_q != SEG_PH2)
    |=> ext_q == $past(ext_q)); // R10
endmodule

// File: rtl/can_bit_timing.sv
`timescale 1ns/1ps
module can_bit_timing #(
  parameter int BRP_W = 8,
  parameter int LEN_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [LEN_W-1:0] prop_len_i,
  input  logic [LEN_W-1:0] ph1_len_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic             idle_i,
  input  logic             tx_i,
  input  logic             rx_i,
  output logic             tq_o,
  output logic [1:0]       seg_o,
  output logic             sample_o,
  output logic             tx_point_o,
  output logic             rx_bit_o
);
  logic tick_w, rx_sync_w, edge_w;

  can_bt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .brp_i  (brp_i),
    .tick_o (tick_w)
  );

  can_bt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .tick_i (tick_w),
    .rx_o   (rx_sync_w),
    .edge_o (edge_w)
  );

  can_bt_seq #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .edge_i     (edge_w),
    .idle_i     (idle_i),
    .tx_i       (tx_i),
    .rx_i       (rx_sync_w),
    .prop_i     (prop_len_i),
    .ph1_i      (ph1_len_i),
    .ph2_i      (ph2_len_i),
    .sjw_i      (sjw_i),
    .seg_o      (seg_o),
    .sample_o   (sample_o),
    .tx_point_o (tx_point_o),
    .rx_bit_o   (rx_bit_o)
  );

  assign tq_o = tick_w;

  AST_STROBE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o || tx_point_o) |-> tq_o); // R4
endmodule

// File: tb/sim_can_bit_timing.sv
`timescale 1ns/1ps
module sim_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] brp = 8'd4;
  logic [2:0] prop = 3'd2, ph1 = 3'd3, ph2 = 3'd3;
  logic [1:0] sjw = 2'd1;
  logic       idle = 1'b0, tx = 1'b1, rx = 1'b1;
  logic       tq, sample, txp, rx_bit;
  logic [1:0] seg;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  can_bit_timing u0 (
    .clk_i(clk), .rst_ni(rst_n), .brp_i(brp), .prop_len_i(prop),
    .ph1_len_i(ph1), .ph2_len_i(ph2), .sjw_i(sjw), .idle_i(idle),
    .tx_i(tx), .rx_i(rx), .tq_o(tq), .seg_o(seg), .sample_o(sample),
    .tx_point_o(txp), .rx_bit_o(rx_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tx();
    do @(negedge clk); while (!txp);
  endtask

  task automatic wait_sample();
    do @(negedge clk); while (!sample);
  endtask

  task automatic skip_ticks(input int k);
    int n = 0;
    while (n < k) begin
      @(negedge clk);
      if (tq) n++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic ticks_to_sample(input int start, output int t);
    t = start;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tq) begin
        t++;
        if (sample) break;
      end
    end
  endtask

  task automatic ticks_to_tx(input int start, output int t);
    t = start;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tq) begin
        t++;
        if (txp) break;
      end
    end
  endtask

  task automatic clocks_per_tq(output int c);
    do @(negedge clk); while (!tq);
    c = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      c++;
      if (tq) break;
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R2 seg", int'(seg), 0);
    chk("R2 sample", int'(sample), 0);
    chk("R2 txp", int'(txp), 0);
    chk("R2 rx_bit", int'(rx_bit), 1);
  endtask

  task automatic t_prescaler(input int exp);
    int c;
    clocks_per_tq(c);
    chk("R1 clocks per quantum", c, exp);
  endtask

  task automatic t_nominal();
    int t;
    wait_sample();
    ticks_to_sample(0, t);
    chk("R3 sample to sample", t, 12);
    @(posedge clk); #1;
    chk("R4 seg after sample", int'(seg), 3);
    wait_tx();
    @(posedge clk); #1;
    chk("R4 seg after tx point", int'(seg), 0);
    ticks_to_sample(0, t);
    chk("R4 tx point to sample", t, 8);
    wait_tx();
    ticks_to_tx(0, t);
    chk("R3 bit length", t, 12);
  endtask

  task automatic t_late(input int k, input int exp);
    int t;
    wait_tx();
    skip_ticks(k);
    rx = 1'b0;
    ticks_to_sample(k, t);
    chk("R6 late edge", t, exp);
    rx = 1'b1;
  endtask

  task automatic t_early(input int j, input int exp);
    int t;
    wait_sample();
    skip_ticks(j);
    rx = 1'b0;
    ticks_to_sample(j, t);
    chk("R7 early edge", t, exp);
    rx = 1'b1;
  endtask

  task automatic t_sync_edge();
    int t;
    wait_tx();
    skip_ticks(0);
    rx = 1'b0;
    ticks_to_sample(0, t);
    chk("R8 edge in sync", t, 8);
    rx = 1'b1;
  endtask

  task automatic t_one_per_bit();
    int t;
    wait_tx();
    skip_ticks(1);
    rx = 1'b0;
    skip_ticks(1);
    rx = 1'b1;
    skip_ticks(1);
    rx = 1'b0;
    ticks_to_sample(3, t);
    chk("R10 second edge ignored", t, 9);
    rx = 1'b1;
  endtask

  task automatic t_tx_dominant_and_rise();
    int t;
    wait_tx();
    tx = 1'b0;
    skip_ticks(2);
    rx = 1'b0;
    ticks_to_sample(2, t);
    chk("R11 no resync while dominant", t, 8);
    @(negedge clk);
    chk("R5 sampled dominant", int'(rx_bit), 0);
    wait_tx();
    tx = 1'b1;
    skip_ticks(2);
    rx = 1'b1;
    ticks_to_sample(2, t);
    chk("R9 rising edge ignored", t, 8);
    @(negedge clk);
    chk("R5 sampled recessive", int'(rx_bit), 1);
  endtask

  task automatic t_hard();
    int t, t2;
    idle = 1'b1;
    wait_tx();
    skip_ticks(5);
    rx = 1'b0;
    ticks_to_tx(5, t);
    chk("R12 hard sync tx point", t, 6);
    ticks_to_sample(t, t2);
    chk("R12 hard sync sample", t2, 13);
    idle = 1'b0;
    rx = 1'b1;
  endtask

  task automatic t_min_config();
    int t;
    rst_n = 1'b0;
    brp = 8'd0; prop = 3'd0; ph1 = 3'd0; ph2 = 3'd0; sjw = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_prescaler(1);
    wait_tx();
    ticks_to_tx(0, t);
    chk("R3 minimum bit with phase 2 clamp", t, 5);
    wait_tx();
    ticks_to_sample(0, t);
    chk("R4 minimum tx point to sample", t, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_prescaler(5);
    t_nominal();
    t_late(1, 9);
    t_late(3, 10);
    t_early(3, 11);
    t_early(0, 10);
    t_sync_edge();
    t_one_per_bit();
    t_tx_dominant_and_rise();
    t_hard();
    t_late(2, 10);
    t_min_config();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule